// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block merges eight interrupt request lines into a single interrupt output for a host processor. It holds a pending-request register, a mask register and an in-service register. It picks the most urgent unmasked request under a priority order that is fixed out of reset and can be rotated by command. When the host acknowledges, the block returns an 8-bit vector number, which is a programmable base plus the level index.

Software sets the block up with a short sequence of initialization words on a one-address-bit write bus. After that sequence it issues operation words: a mask write, several forms of end-of-interrupt, a priority-set command and an automatic-rotation mode switch. Only single (non-cascaded) operation is built. A cascade word is accepted in the sequence and discarded.

Top module: `irqc_top`

## Requirements
- R1: After reset `int_out` and `vec_valid` are 0, every level is masked (mask = FFh), IR0 has the highest priority and IR7 the lowest.
- R2: A write with `wr_addr`=0 and `wr_data[4]`=1 starts initialization. In that word, bit 3 selects level triggering, bit 1 selects single mode and bit 0 announces a fourth word. The next write with `wr_addr`=1 sets the vector base. If bit 1 was 0, one more `wr_addr`=1 write is consumed and ignored. If bit 0 was 1, the following `wr_addr`=1 write sets automatic EOI from its bit 1.
- R3: Outside initialization, a write with `wr_addr`=1 loads the mask. Mask bit n = 1 blocks IRn (FEh enables only IR0). A masked edge request stays pending and is served once it is unmasked. Initialization leaves the mask unchanged.
- R4: In edge mode a rising edge on `irq_in[n]` latches a request that stays pending until it is acknowledged, or until initialization starts. In level mode the request follows the input line.
- R5: `int_out` is 1 one cycle after the state holds an unmasked request whose priority is above every in-service level.
- R6: A one-cycle `ack` while a request wins clears its pending bit and sets its in-service bit. In the next cycle it gives `vec_valid`=1 with `vec_out` = base + n (mod 256). An `ack` with no winner gives no `vec_valid`.
- R7: A write with `wr_addr`=0, bits 4:3 = 00 and bits 7:5 = 001 clears the in-service bit of the highest-priority in-service level.
- R8: Bits 7:5 = 011 clear the in-service bit of the level in bits 2:0.
- R9: Bits 7:5 = 101 act like R7 and then make the cleared level the lowest priority. Bits 7:5 = 111 act like R8 and make level bits 2:0 the lowest.
- R10: Bits 7:5 = 110 make the level in bits 2:0 the lowest priority without touching in-service bits.
- R11: With automatic EOI, acknowledge sets no in-service bit. Bits 7:5 = 100 turn on rotation at acknowledge, so the acknowledged level becomes the lowest. Bits 7:5 = 000 turn it off. Initialization turns it off.
- R12: Initialization clears the in-service bits and restores IR0 as the highest priority.
- R13: A write with `wr_addr`=0, bit 4 = 0 and bit 3 = 1 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the command bus |
| wr_addr | input | 1 | Command address bit |
| wr_data | input | 8 | Command write data |
| irq_in | input | 8 | Interrupt request lines IR0..IR7 |
| ack | input | 1 | One-cycle acknowledge from the host |
| int_out | output | 1 | Interrupt request to the host |
| vec_out | output | 8 | Vector number, valid with vec_valid |
| vec_valid | output | 1 | Vector strobe, one cycle after a winning ack |

## Verification
The block is tried with single requests behind a partial mask, with simultaneous pairs of requests, and with requests that arrive while a higher or lower level is in service. These patterns separate masking from prioritisation and show whether the in-service register blocks nested levels. The same pairs are repeated after each rotation command and after a priority set. Because the expected winner differs from the fixed-order answer in those runs, a wrong rotation pointer shows up directly in the vector. Level triggering with automatic EOI is run with held lines and back-to-back acknowledges, which exposes whether an in-service bit is left set or rotation is applied when it is switched off.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  typedef enum logic [1:0] {S_RDY, S_BASE, S_CASC, S_MODE} init_st_t;
  typedef enum logic [2:0] {
    OP_NONE, OP_EOI_NS, OP_EOI_SP, OP_ROT_NS, OP_ROT_SP, OP_SETPRI, OP_RAEOI_ON, OP_RAEOI_OFF
  } op_t;
endpackage

// File: rtl/irqc_cmd.sv
`timescale 1ns/1ps
module irqc_cmd
  import irqc_pkg::*;
#(
  parameter int NLVL = 8,
  parameter int DW   = 8,
  localparam int LW  = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   base,
  output logic            level_mode,
  output logic            aeoi,
  output logic [NLVL-1:0] mask,
  output logic            init_pulse,
  output op_t             op,
  output logic [LW-1:0]   op_lvl
);
  init_st_t st_q;
  logic single_q, ic4_q;
  logic is_op_wr, is_hi_wr;

  assign init_pulse = wr_en && !wr_addr && wr_data[4];
  assign is_op_wr   = wr_en && !wr_addr && !wr_data[4] && !wr_data[3] && (st_q == S_RDY);
  assign is_hi_wr   = wr_en && wr_addr;
  assign op_lvl     = wr_data[LW-1:0];

  always_comb begin
    op = OP_NONE;
    if (is_op_wr) begin
      case (wr_data[7:5])
        3'b001:  op = OP_EOI_NS;
        3'b011:  op = OP_EOI_SP;
        3'b101:  op = OP_ROT_NS;
        3'b111:  op = OP_ROT_SP;
        3'b110:  op = OP_SETPRI;
        3'b100:  op = OP_RAEOI_ON;
        3'b000:  op = OP_RAEOI_OFF;
        default: op = OP_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_RDY;
      single_q   <= 1'b1;
      ic4_q      <= 1'b0;
      base       <= '0;
      level_mode <= 1'b0;
      aeoi       <= 1'b0;
      mask       <= '1;
    end else if (init_pulse) begin
      st_q       <= S_BASE;
      level_mode <= wr_data[3];
      single_q   <= wr_data[1];
      ic4_q      <= wr_data[0];
      aeoi       <= 1'b0;
    end else if (is_hi_wr) begin
      case (st_q)
        S_BASE: begin
          base <= wr_data;
          st_q <= !single_q ? S_CASC : (ic4_q ? S_MODE : S_RDY);
        end
        S_CASC: st_q <= ic4_q ? S_MODE : S_RDY;
        S_MODE: begin
          aeoi <= wr_data[1];
          st_q <= S_RDY;
        end
        default: mask <= wr_data[NLVL-1:0];
      endcase
    end
  end

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(is_hi_wr && st_q == S_RDY && !init_pulse) |=> $stable(mask));
endmodule

// File: rtl/irqc_arb.sv
`timescale 1ns/1ps
module irqc_arb #(
  parameter int NLVL = 8,
  localparam int LW  = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] req,
  input  logic [NLVL-1:0] mask,
  input  logic [NLVL-1:0] isr,
  input  logic [LW-1:0]   lowest,
  output logic            int_req,
  output logic [LW-1:0]   win,
  output logic            svc_any,
  output logic [LW-1:0]   svc
);
  logic          done;
  logic [LW-1:0] idx;

  // Walk from the level just above the lowest one; wraps because NLVL is a power of two.
  always_comb begin
    int_req = 1'b0;
    win     = '0;
    svc_any = 1'b0;
    svc     = '0;
    done    = 1'b0;
    idx     = '0;
    for (int i = 0; i < NLVL; i++) begin
      idx = LW'(int'(lowest) + 1 + i);
      if (!done) begin
        if (isr[idx]) begin
          done = 1'b1;
        end else if (req[idx] && !mask[idx]) begin
          done    = 1'b1;
          int_req = 1'b1;
          win     = idx;
        end
      end
      if (!svc_any && isr[idx]) begin
        svc_any = 1'b1;
        svc     = idx;
      end
    end
  end

  // R5
  win_ok_chk: assert property (@(posedge clk) disable iff (rst)
    int_req |-> (req[win] && !mask[win] && !isr[win]));
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NLVL = 8,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [NLVL-1:0] irq_in,
  input  logic            ack,
  output logic            int_out,
  output logic [DW-1:0]   vec_out,
  output logic            vec_valid
);
  localparam int LW = $clog2(NLVL);

  logic [DW-1:0]   base;
  logic            level_mode, aeoi, init_pulse;
  logic [NLVL-1:0] mask;
  op_t             op;
  logic [LW-1:0]   op_lvl;

  logic [NLVL-1:0] irq_q, irr_q, isr_q, req, isr_n, clr;
  logic [LW-1:0]   lowest_q, lowest_n, win, svc;
  logic            raeoi_q, int_req, svc_any, grant;

  irqc_cmd #(.NLVL(NLVL), .DW(DW)) u_cmd (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .base(base), .level_mode(level_mode), .aeoi(aeoi), .mask(mask),
    .init_pulse(init_pulse), .op(op), .op_lvl(op_lvl)
  );

  assign req = level_mode ? irq_in : irr_q;

  irqc_arb #(.NLVL(NLVL)) u_arb (
    .clk(clk), .rst(rst), .req(req), .mask(mask), .isr(isr_q), .lowest(lowest_q),
    .int_req(int_req), .win(win), .svc_any(svc_any), .svc(svc)
  );

  assign grant = ack && int_req;
  assign clr   = grant ? (NLVL'(1) << win) : '0;

  always_comb begin
    isr_n    = isr_q;
    lowest_n = lowest_q;
    if (grant && aeoi && raeoi_q) lowest_n = win;
    case (op)
      OP_EOI_NS: if (svc_any) isr_n[svc] = 1'b0;
      OP_EOI_SP: isr_n[op_lvl] = 1'b0;
      OP_ROT_NS: if (svc_any) begin
        isr_n[svc] = 1'b0;
        lowest_n   = svc;
      end
      OP_ROT_SP: begin
        isr_n[op_lvl] = 1'b0;
        lowest_n      = op_lvl;
      end
      OP_SETPRI: lowest_n = op_lvl;
      default: ;
    endcase
    if (grant && !aeoi) isr_n[win] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q     <= '0;
      irr_q     <= '0;
      isr_q     <= '0;
      lowest_q  <= LW'(NLVL - 1);
      raeoi_q   <= 1'b0;
      int_out   <= 1'b0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      irq_q     <= irq_in;
      int_out   <= int_req;
      vec_valid <= grant;
      vec_out   <= grant ? DW'(base + DW'(win)) : '0;
      if (init_pulse) begin
        irr_q    <= '0;
        isr_q    <= '0;
        lowest_q <= LW'(NLVL - 1);
        raeoi_q  <= 1'b0;
      end else begin
        irr_q    <= (irr_q & ~clr) | (irq_in & ~irq_q);
        isr_q    <= isr_n;
        lowest_q <= lowest_n;
        if (op == OP_RAEOI_ON)  raeoi_q <= 1'b1;
        if (op == OP_RAEOI_OFF) raeoi_q <= 1'b0;
      end
    end
  end

  // R6
  isr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (grant && !aeoi && !init_pulse) |=> isr_q[$past(win)]);
  // R11
  aeoi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (grant && aeoi) |=> !isr_q[$past(win)]);
  // R8
  eoi_sp_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_EOI_SP && !(grant && win == op_lvl)) |=> !isr_q[$past(op_lvl)]);
  // R6
  vec_ack_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(ack));
endmodule

// File: tb/irqc_top_bench.sv
`timescale 1ns/1ps
module irqc_top_bench;
  logic clk = 0, rst = 1, wr_en = 0, wr_addr = 0, ack = 0;
  logic [7:0] wr_data = 0, irq = 0;
  logic int_out, vec_valid;
  logic [7:0] vec_out;
  int nchk = 0, nfail = 0;
  bit done = 0, started = 0;

  irqc_top u_irqc_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_in(irq), .ack(ack), .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference model
  logic [7:0] m_mask, m_irr, m_isr, m_base, m_prev;
  int m_lp, m_st;
  bit m_level, m_aeoi, m_raeoi, m_single, m_ic4;
  bit e_int, e_vv;
  int e_vec;

  always @(posedge clk) begin : model
    int win, svc, idx, l;
    logic [7:0] rq;
    bit blocked, grant, icw1;
    started = 1;
    if (rst) begin
      m_mask = 8'hFF; m_irr = 0; m_isr = 0; m_base = 0; m_prev = 0;
      m_lp = 7; m_st = 0; m_level = 0; m_aeoi = 0; m_raeoi = 0; m_single = 1; m_ic4 = 0;
      e_int = 0; e_vv = 0; e_vec = 0;
    end else begin
      win = -1; svc = -1; blocked = 0;
      rq = m_level ? irq : m_irr;
      for (int k = 0; k < 8; k++) begin
        idx = (m_lp + 1 + k) % 8;
        if (!blocked && win < 0) begin
          if (m_isr[idx]) blocked = 1;
          else if (rq[idx] && !m_mask[idx]) win = idx;
        end
        if (svc < 0 && m_isr[idx]) svc = idx;
      end
      grant = ack && (win >= 0);
      e_int = (win >= 0);
      e_vv  = grant;
      e_vec = grant ? (m_base + win) % 256 : 0;
      icw1 = wr_en && !wr_addr && wr_data[4];
      l = wr_data[2:0];
      if (icw1) begin
        m_irr = 0; m_isr = 0; m_lp = 7; m_raeoi = 0; m_aeoi = 0;
        m_level = wr_data[3]; m_single = wr_data[1]; m_ic4 = wr_data[0]; m_st = 1;
      end else begin
        if (grant) m_irr[win] = 0;
        m_irr = m_irr | (irq & ~m_prev);
        if (grant && m_aeoi && m_raeoi) m_lp = win;
        if (wr_en && !wr_addr && !wr_data[4] && !wr_data[3] && m_st == 0) begin
          case (wr_data[7:5])
            3'b001: if (svc >= 0) m_isr[svc] = 0;
            3'b011: m_isr[l] = 0;
            3'b101: if (svc >= 0) begin m_isr[svc] = 0; m_lp = svc; end
            3'b111: begin m_isr[l] = 0; m_lp = l; end
            3'b110: m_lp = l;
            3'b100: m_raeoi = 1;
            3'b000: m_raeoi = 0;
            default: ;
          endcase
        end
        if (grant && !m_aeoi) m_isr[win] = 1;
        if (wr_en && wr_addr) begin
          if (m_st == 1) begin m_base = wr_data; m_st = !m_single ? 2 : (m_ic4 ? 3 : 0); end
          else if (m_st == 2) m_st = m_ic4 ? 3 : 0;
          else if (m_st == 3) begin m_aeoi = wr_data[1]; m_st = 0; end
          else m_mask = wr_data;
        end
      end
      m_prev = irq;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) if (started && !done) begin
    chk(int_out === e_int, "R5 int_out vs model", int_out, e_int);
    chk(vec_valid === e_vv, "R6 vec_valid vs model", vec_valid, e_vv);
    if (e_vv) chk(vec_out === 8'(e_vec), "R6 vec_out vs model", vec_out, e_vec);
  end

  task automatic settle(input int n); repeat (n) @(negedge clk); endtask
  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic set_irq(input logic [7:0] v); @(negedge clk); irq = v; endtask
  task automatic pulse(input logic [7:0] v); set_irq(v); set_irq(0); endtask
  task automatic do_ack(input int exp, input string tag);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    chk(vec_valid === 1'b1 && vec_out === 8'(exp), tag, {vec_valid, vec_out}, 256 + exp);
    settle(2);
  endtask
  task automatic chk_int(input bit exp, input string tag);
    settle(3);
    chk(int_out === exp, tag, int_out, exp);
  endtask

  initial begin
    settle(4); rst = 0;
    settle(2);
    chk(int_out === 0 && vec_valid === 0, "R1 reset outputs", {int_out, vec_valid}, 0);
    pulse(8'h08); chk_int(0, "R1 all masked after reset");
    // edge mode, single, fourth word, normal EOI, base 20h
    wr(0, 8'h13); wr(1, 8'h20); wr(1, 8'h01); wr(1, 8'hFE);
    pulse(8'h02); chk_int(0, "R3 IR1 masked");
    pulse(8'h01); chk_int(1, "R3 IR0 enabled by FEh");
    do_ack(8'h20, "R2 base vector for IR0");
    chk_int(0, "R6 pending masked, none active");
    wr(0, 8'h20);
    wr(1, 8'h00); chk_int(1, "R4 latched IR1 served after unmask");
    do_ack(8'h21, "R4 latched IR1 vector"); wr(0, 8'h20);
    pulse(8'h24); chk_int(1, "R5 pair pending");
    do_ack(8'h22, "R12 fixed order IR2 over IR5");
    chk_int(0, "R5 IR5 below in-service IR2");
    wr(0, 8'h20); chk_int(1, "R7 nonspecific EOI frees IR5");
    do_ack(8'h25, "R7 IR5 vector");
    pulse(8'h40); chk_int(0, "R5 IR6 below in-service IR5");
    wr(0, 8'h65); chk_int(1, "R8 specific EOI of IR5");
    do_ack(8'h26, "R8 IR6 vector"); wr(0, 8'h20);
    // rotation
    pulse(8'h10); settle(3); do_ack(8'h24, "R9 IR4 vector");
    wr(0, 8'hA0);
    pulse(8'h28); settle(3); do_ack(8'h25, "R9 IR5 highest after rotate");
    wr(0, 8'h20); settle(3); do_ack(8'h23, "R9 IR3 after IR5"); wr(0, 8'h20);
    wr(0, 8'hE1);
    pulse(8'h82); settle(3); do_ack(8'h27, "R9 rotate specific IR7 over IR1");
    wr(0, 8'h20); settle(3); do_ack(8'h21, "R9 IR1 next"); wr(0, 8'h20);
    // set priority: IR6 lowest, IR7 highest
    wr(0, 8'hC6);
    pulse(8'h41); settle(3); do_ack(8'h20, "R10 IR0 over IR6");
    wr(0, 8'h68); chk_int(0, "R13 read-select word left IR0 in service");
    wr(0, 8'h20); settle(3); do_ack(8'h26, "R10 IR6 last"); wr(0, 8'h20);
    settle(3);
    @(negedge clk); ack = 1; @(negedge clk); ack = 0;
    chk(vec_valid === 0, "R6 ack without winner", vec_valid, 0);
    // re-init with cascade word present
    wr(0, 8'h11); wr(1, 8'h60); wr(1, 8'h55); wr(1, 8'h01); wr(1, 8'hF7);
    pulse(8'h09); settle(3); do_ack(8'h63, "R2 cascade word skipped, base 60h");
    wr(0, 8'h20); chk_int(0, "R3 only IR3 enabled");
    wr(1, 8'h00);
    pulse(8'h81); settle(3); do_ack(8'h60, "R12 IR0 highest after init");
    wr(0, 8'h20); settle(3); do_ack(8'h67, "R12 IR7 after IR0"); wr(0, 8'h20);
    // level mode with automatic EOI
    wr(0, 8'h1B); wr(1, 8'h40); wr(1, 8'h03);
    set_irq(8'h08); chk_int(1, "R4 level request");
    do_ack(8'h43, "R11 level IR3 vector");
    chk_int(1, "R11 no in-service bit with auto EOI");
    set_irq(8'h00); chk_int(0, "R4 level request follows line");
    wr(0, 8'h80);
    set_irq(8'h24); settle(3);
    do_ack(8'h42, "R11 rotate at ack IR2");
    do_ack(8'h45, "R11 IR5 after IR2 rotated");
    wr(0, 8'h00); settle(2);
    do_ack(8'h42, "R11 rotation off IR2");
    do_ack(8'h42, "R11 rotation off IR2 again");
    set_irq(8'h00); settle(5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule